// File: doc/BRIEF.md
# Light Threshold Interrupt with Persistence Filter

This block watches the channel-0 result of a light-sensing converter and decides when to interrupt the host. Each time an integration period ends, a strobe presents a 16-bit result. The block compares that result against a low and a high bound that software has programmed. A small counter tracks how many periods in a row the result has stayed outside the window. When the count reaches the programmed persistence setting, a pending flag is latched. It stays set until a clear command arrives.

Software reaches the block through byte-wide register writes and a separate command byte. The writes set the two bounds, one byte at a time, and the interrupt-control byte. The command byte carries the clear request. A power-control value gates all evaluation. The pending flag is always visible on a status output. The level interrupt line follows it only in the modes that drive that line.

Top module: `lux_irq_top`

## Requirements
- R1: Reset, asynchronous and active low, clears both bounds to 0x0000, the control byte (mode 0, persistence 0), the run counter and the pending flag. While reset is held, `irq_o` and `stat_o` are 0.
- R2: Register writes (`wr_en` high) update one byte at a time. Address 2 is the low-bound low byte and address 3 its high byte. Address 4 is the high-bound low byte and address 5 its high byte. Address 6 is the control byte, with mode in bits 1:0 and persistence in bits 7:4. Any other address is ignored.
- R3: A result is outside the window only when it is strictly less than the low bound or strictly greater than the high bound. A result equal to either bound is inside.
- R4: With persistence 0, every end-of-integration strobe that is evaluated sets the pending flag, whether the result is inside or outside the window.
- R5: With persistence N from 1 to 15, the pending flag sets on the Nth consecutive evaluated out-of-window strobe and not earlier. After it sets, the run counter holds its value until a clear.
- R6: An evaluated in-window strobe returns the run counter to zero.
- R7: The pending flag stays set until a clear. A clear is a command byte (`cmd_valid` high) with bit 7 and bit 6 both 1. A byte with bit 7 at 0 has no effect.
- R8: Strobes are evaluated only while `pwr_ctrl` equals 0x03. Any other value holds the run counter at zero and sets nothing.
- R9: Mode 0 disables interrupt generation and holds the run counter at zero.
- R10: In mode 1 (level), `irq_o` and `stat_o` both follow the pending flag. In mode 2 (alert), `stat_o` follows the pending flag and `irq_o` stays 0.
- R11: Mode 3 (test) forces the pending flag to set on every cycle without a clear, whatever the power state. `irq_o` is driven in this mode.
- R12: A clear in the same cycle as a strobe wins, and the pending flag ends that cycle at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 8 | Register write data |
| cmd_valid | input | 1 | Command byte valid |
| cmd_byte | input | 8 | Command byte; bit 7 must be 1, bit 6 requests a clear |
| pwr_ctrl | input | 8 | Power-control value; 0x03 means running |
| eoi | input | 1 | End-of-integration strobe |
| result | input | 16 | Channel-0 conversion result |
| irq_o | output | 1 | Level interrupt line |
| stat_o | output | 1 | Pending-interrupt status and test flag |

## Verification
The embedded properties check the behaviours that hold on every cycle. A clear empties the pending flag on the next cycle. The flag holds otherwise. The run counter drops to zero when power is off or the mode is 0. The counter stays frozen once the flag has fired. Test mode sets the flag. Nothing becomes pending while power is off, except in test mode. Only the bench scenarios can show the counting itself: firing on exactly the Nth out-of-window period, strict comparison at the bounds, restart after an in-window result, byte-wise assembly of the bounds, the alert mode keeping the line low, and the clear-over-strobe priority.

// File: rtl/lux_irq_pkg.sv
package lux_irq_pkg;
  localparam int DATA_W    = 16;
  localparam int PERSIST_W = 4;
  localparam int ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] ADDR_LOW_BASE  = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_HIGH_BASE = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 4'h6;
  localparam logic [7:0]        PWR_RUN        = 8'h03;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_LEVEL = 2'd1,
    MODE_ALERT = 2'd2,
    MODE_TEST  = 2'd3
  } irq_mode_e;
endpackage

// File: rtl/lux_irq_regs.sv
module lux_irq_regs
  import lux_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PERSIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  output logic [DW-1:0]     lo_bound_o,
  output logic [DW-1:0]     hi_bound_o,
  output irq_mode_e         mode_o,
  output logic [PW-1:0]     persist_o,
  output logic              clr_o
);
  localparam int NBYTES = DW / 8;

  logic [DW-1:0] lo_q, lo_n, hi_q, hi_n;
  irq_mode_e     mode_q, mode_n;
  logic [PW-1:0] pers_q, pers_n;
  logic          unused_bits;

  assign unused_bits = ^{wr_data[3:2], cmd_byte[5:0]};

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    mode_n = mode_q;
    pers_n = pers_q;
    if (wr_en) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_addr == ADDR_W'(ADDR_LOW_BASE + b))  lo_n[b*8 +: 8] = wr_data;
        if (wr_addr == ADDR_W'(ADDR_HIGH_BASE + b)) hi_n[b*8 +: 8] = wr_data;
      end
      if (wr_addr == ADDR_CTRL) begin
        mode_n = irq_mode_e'(wr_data[1:0]);
        pers_n = wr_data[4 +: PW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= MODE_OFF;
      pers_q <= '0;
    end else begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      mode_q <= mode_n;
      pers_q <= pers_n;
    end
  end

  assign clr_o      = cmd_valid && cmd_byte[7] && cmd_byte[6];
  assign lo_bound_o = lo_q;
  assign hi_bound_o = hi_q;
  assign mode_o     = mode_q;
  assign persist_o  = pers_q;
endmodule

// File: rtl/lux_irq_window.sv
module lux_irq_window #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] lo_bound_i,
  input  logic [DW-1:0] hi_bound_i,
  output logic          outside_o
);
  logic below, above;
  assign below     = sample_i < lo_bound_i;
  assign above     = sample_i > hi_bound_i;
  assign outside_o = below || above;
endmodule

// File: rtl/lux_irq_persist.sv
module lux_irq_persist
  import lux_irq_pkg::*;
#(
  parameter int PW = PERSIST_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          eoi_i,
  input  logic          outside_i,
  input  logic          pwr_on_i,
  input  irq_mode_e     mode_i,
  input  logic [PW-1:0] persist_i,
  output logic          pend_o,
  output logic [PW-1:0] cnt_o
);
  logic [PW-1:0] cnt_q, cnt_n;
  logic          pend_q, pend_n;
  logic [PW:0]   cnt_inc;
  logic          eval_en;
  logic          reach;

  assign eval_en = pwr_on_i && (mode_i == MODE_LEVEL || mode_i == MODE_ALERT);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign reach   = cnt_inc >= {1'b0, persist_i};

  always_comb begin
    cnt_n  = cnt_q;
    pend_n = pend_q;
    if (clr_i) begin
      cnt_n  = '0;
      pend_n = 1'b0;
    end else if (mode_i == MODE_TEST) begin
      cnt_n  = '0;
      pend_n = 1'b1;
    end else if (!eval_en) begin
      cnt_n  = '0;
    end else if (eoi_i && !pend_q) begin
      if (persist_i == '0) begin
        pend_n = 1'b1;
      end else if (outside_i) begin
        cnt_n = cnt_inc[PW] ? '1 : cnt_inc[PW-1:0];
        if (reach) pend_n = 1'b1;
      end else begin
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !pend_o);
  assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o);
  assert_power_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on_i |=> (cnt_o == '0));
  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i && eval_en) |=> (cnt_o == $past(cnt_o)));
  assert_test_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_TEST && !clr_i) |=> pend_o);
endmodule

// File: rtl/lux_irq_top.sv
module lux_irq_top
  import lux_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PERSIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  input  logic [7:0]        pwr_ctrl,
  input  logic              eoi,
  input  logic [DW-1:0]     result,
  output logic              irq_o,
  output logic              stat_o
);
  logic [DW-1:0] lo_bound, hi_bound;
  irq_mode_e     mode;
  logic [PW-1:0] persist, cnt;
  logic          clr, outside, pwr_on, pend;

  assign pwr_on = (pwr_ctrl == PWR_RUN);

  lux_irq_regs #(.DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .lo_bound_o(lo_bound),
    .hi_bound_o(hi_bound), .mode_o(mode), .persist_o(persist), .clr_o(clr)
  );

  lux_irq_window #(.DW(DW)) u_win (
    .sample_i(result), .lo_bound_i(lo_bound), .hi_bound_i(hi_bound), .outside_o(outside)
  );

  lux_irq_persist #(.PW(PW)) u_pers (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .eoi_i(eoi), .outside_i(outside),
    .pwr_on_i(pwr_on), .mode_i(mode), .persist_i(persist), .pend_o(pend), .cnt_o(cnt)
  );

  assign stat_o = pend;
  assign irq_o  = pend && (mode == MODE_LEVEL || mode == MODE_TEST);

  assert_mode_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> (cnt == '0));
  assert_no_set_unpowered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on && mode != MODE_TEST && !stat_o) |=> !stat_o);
endmodule

// File: tb/sim_lux_irq_top.sv
module sim_lux_irq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, cmd_valid, eoi;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data, cmd_byte, pwr_ctrl;
  logic [15:0] result;
  logic        irq_o, stat_o;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lux_irq_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .pwr_ctrl(pwr_ctrl), .eoi(eoi),
    .result(result), .irq_o(irq_o), .stat_o(stat_o)
  );

  // {clear_first, ctrl, result, exp_stat, exp_irq}; bounds 0x0100..0x0F00
  localparam logic [26:0] VEC [13] = '{
    {1'b1, 8'h31, 16'h0050, 1'b0, 1'b0},  // R5 run 1, below
    {1'b0, 8'h31, 16'h0F01, 1'b0, 1'b0},  // R5 run 2, above
    {1'b0, 8'h31, 16'h0100, 1'b0, 1'b0},  // R3 R6 equal low -> restart
    {1'b0, 8'h31, 16'h00FF, 1'b0, 1'b0},  // R5 run 1
    {1'b0, 8'h31, 16'hFFFF, 1'b0, 1'b0},  // R5 run 2
    {1'b0, 8'h31, 16'h0000, 1'b1, 1'b1},  // R5 third -> fire
    {1'b0, 8'h31, 16'h0500, 1'b1, 1'b1},  // R7 latched
    {1'b1, 8'h31, 16'h0F00, 1'b0, 1'b0},  // R3 equal high inside
    {1'b1, 8'h01, 16'h0500, 1'b1, 1'b1},  // R4 persist 0 fires in range
    {1'b1, 8'h02, 16'h0500, 1'b1, 1'b0},  // R10 alert: status only
    {1'b1, 8'h12, 16'h0500, 1'b0, 1'b0},  // R10 alert in range
    {1'b0, 8'h12, 16'h2000, 1'b1, 1'b0},  // R10 alert fires, line low
    {1'b1, 8'h10, 16'h2000, 1'b0, 1'b0}   // R9 mode 0 disabled
  };

  task automatic check(input logic es, input logic ei, input string tag);
    n_chk++;
    if (stat_o !== es || irq_o !== ei) begin
      n_fail++;
      $display("FAIL %s: stat/irq actual %b%b expected %b%b", tag, stat_o, irq_o, es, ei);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_byte = c;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic strobe(input logic [15:0] r);
    eoi = 1'b1; result = r;
    tick();
    eoi = 1'b0;
  endtask

  task automatic set_bounds(input logic [15:0] lo, input logic [15:0] hi);
    wr(4'h2, lo[7:0]); wr(4'h3, lo[15:8]);
    wr(4'h4, hi[7:0]); wr(4'h5, hi[15:8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cmd_valid = 1'b0;
    cmd_byte = '0; pwr_ctrl = 8'h03; eoi = 1'b0; result = '0;
    tick(); tick();
    check(1'b0, 1'b0, "R1 reset outputs");
    rst_n = 1'b1;
    tick();
    set_bounds(16'h0100, 16'h0F00);

    for (int i = 0; i < 13; i++) begin
      wr(4'h6, VEC[i][25:18]);
      if (VEC[i][26]) cmd(8'hC0);
      strobe(VEC[i][17:2]);
      check(VEC[i][1], VEC[i][0], $sformatf("table row %0d", i));
    end

    // R2: rewrite one byte of the high bound -> 0x0FFF
    cmd(8'hC0); wr(4'h6, 8'h11); wr(4'h4, 8'hFF);
    strobe(16'h0F80);
    check(1'b0, 1'b0, "R2 byte write widens bound");
    strobe(16'h1000);
    check(1'b1, 1'b1, "R2 R3 above new bound");

    // R7: bit 7 missing is ignored, proper clear works
    cmd(8'h40);
    check(1'b1, 1'b1, "R7 clear without bit7 ignored");
    cmd(8'hC0);
    check(1'b0, 1'b0, "R7 clear");

    // R8: no evaluation unless 0x03
    pwr_ctrl = 8'h00; strobe(16'h0000);
    check(1'b0, 1'b0, "R8 power off");
    pwr_ctrl = 8'h01; strobe(16'h0000);
    check(1'b0, 1'b0, "R8 partial power value");

    // R8: power off drops the run
    pwr_ctrl = 8'h03; wr(4'h6, 8'h21);
    strobe(16'h0000);
    check(1'b0, 1'b0, "R8 run 1 of 2");
    pwr_ctrl = 8'h00; tick(); pwr_ctrl = 8'h03;
    strobe(16'h0000);
    check(1'b0, 1'b0, "R8 run restarted after power off");
    strobe(16'h0000);
    check(1'b1, 1'b1, "R5 R8 second run completes");

    // R12: clear wins over same-cycle strobe
    cmd(8'hC0); wr(4'h6, 8'h01);
    cmd_valid = 1'b1; cmd_byte = 8'hC0; eoi = 1'b1; result = 16'h0500;
    tick();
    cmd_valid = 1'b0; eoi = 1'b0;
    check(1'b0, 1'b0, "R12 clear beats strobe");
    strobe(16'h0500);
    check(1'b1, 1'b1, "R12 R4 next strobe fires");

    // R11: test mode forces
    cmd(8'hC0); wr(4'h6, 8'h03); tick();
    check(1'b1, 1'b1, "R11 test mode forces");
    cmd(8'hC0);
    check(1'b0, 1'b0, "R11 clear in test mode");
    tick();
    check(1'b1, 1'b1, "R11 forced again");

    // R1: reset mid-run clears bounds and pending
    rst_n = 1'b0; tick();
    check(1'b0, 1'b0, "R1 reset during test mode");
    rst_n = 1'b1; tick();
    wr(4'h6, 8'h11);
    strobe(16'h0000);
    check(1'b0, 1'b0, "R1 R3 zero bounds, zero inside");
    strobe(16'h0001);
    check(1'b1, 1'b1, "R1 R3 zero bounds, one outside");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule